// File: doc/BRIEF.md
# Multi-format video input front end

This block sits at the entry of a video pipeline. It turns the pixel data that arrives on two 8-bit ports (Y and C) into one internal stream of luma/chroma sample pairs. The stream also carries a horizontal sync strobe, a vertical sync strobe, a field flag, a per-sample active-video qualifier and a flag that says whether the stream can be trusted. Three input formats are supported. The first is a single byte stream with embedded timing reference codes; its syncs are rebuilt from the codes and it may arrive on either port. The second is a single byte stream on the Y port with separate sync inputs. The third is a 16-bit mode with luma on Y, multiplexed Cb/Cr on C and separate syncs.

In the embedded-code mode the line and frame sizes are whatever the codes mark out, so pictures of any size are accepted as long as the picture data avoids the reserved values 0x00 and 0xFF. A change of format or port selection flushes the block, and the stream is reported invalid again until a complete line has been seen.

Top module: `vid_in_frontend`

## Requirements
- R1: `fmt_sel` selects the format: 00 embedded codes, 01 single byte stream with separate syncs, 10 16-bit Y/C. Code 11 is reserved: it produces no `out_act`, `out_hs` or `out_vs` whatever the inputs do.
- R2: In embedded-code mode the byte stream is taken from `y_in` when `port_sel` is 0 and from `c_in` when `port_sel` is 1. The other port is ignored.
- R3: A timing code is the byte sequence FF, 00, 00, XY. In XY, bit 6 is the field bit F, bit 5 the vertical blanking bit V and bit 4 the H bit (1 = end of active video, 0 = start). A code is accepted only if bit 7 = 1, bit 3 = V^H, bit 2 = F^H, bit 1 = F^V and bit 0 = F^V^H. Any other code is ignored completely.
- R4: `out_hs` is a one-cycle strobe. In embedded-code mode it fires on each accepted code with H = 1, in the output cycle right after the XY byte is clocked in. In the separate-sync modes it fires on each rising edge of `hs_in`, in the output cycle after the first high sample.
- R5: `out_vs` is a one-cycle strobe. In embedded-code mode it fires on an accepted code with V = 1 when the previous accepted code had V = 0. In the separate-sync modes it fires on a rising edge of `vs_in`. `out_fid` holds the F bit of the last accepted code, or `fid_in` registered.
- R6: In embedded-code mode, samples are active from the byte after an accepted code with H = 0 and V = 0, up to the next accepted code with H = 1. The four code bytes are never active, and a start code with V = 1 opens no active region.
- R7: In the single byte modes, active bytes alternate chroma then luma, and the first active byte after blanking is chroma. Each luma byte gives one cycle of `out_act` with `out_y` = that luma byte and `out_c` = the chroma byte just before it. `out_act` is never high on two consecutive cycles.
- R8: In the separate-sync modes an input cycle is active when `hs_in` = 0 and `vs_in` = 0 (high means blanking). The 8-bit mode reads only `y_in`.
- R9: In 16-bit mode every active input cycle gives one cycle of `out_act` with `out_y` = `y_in` and `out_c` = `c_in`.
- R10: Latency, in clock edges from the edge that samples a luma byte to the edge that presents it: 4 in embedded-code mode, 1 in the separate-sync modes.
- R11: `out_valid` is low after reset and is cleared by any change of `fmt_sel` or `port_sel`. It rises in the cycle after the second `out_hs` strobe seen since then, and stays high until the next reset or change.
- R12: Reset is synchronous and active low. It clears every output to 0, and so does the cycle in which the configuration changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fmt_sel | input | 2 | Input format select (R1) |
| port_sel | input | 1 | Port used in embedded-code mode, 0 = Y, 1 = C |
| y_in | input | DW | Y port data |
| c_in | input | DW | C port data |
| hs_in | input | 1 | Horizontal sync/blanking, high = blanking |
| vs_in | input | 1 | Vertical sync/blanking, high = blanking |
| fid_in | input | 1 | Field ID input |
| out_y | output | DW | Luma of the current sample |
| out_c | output | DW | Chroma of the current sample |
| out_hs | output | 1 | Horizontal sync strobe |
| out_vs | output | 1 | Vertical sync strobe |
| out_fid | output | 1 | Field flag |
| out_act | output | 1 | Sample qualifier, one cycle per sample pair |
| out_valid | output | 1 | High once a complete line has been seen |

## Verification
The bench sends malformed codes whose prefix is right but whose protection bits are wrong. A decoder that skipped the check would emit a stray sync strobe or open an active region over blanking bytes. It places the code bytes right next to picture data and checks the exact cycle of the first sample. This catches a design that leaks FF/00 code bytes as pixels, or that is off by one in its delay, because the luma/chroma pairing would then shift. It also checks that the chroma phase restarts after each blanking period, that the unselected port is ignored, that a start code during vertical blanking opens nothing, and that a port or format change drops `out_valid` until two fresh line strobes have been counted.

// File: rtl/vin_pkg.sv
// Shared types and helpers for the video input front end.
// Assumes timing codes are carried in the top 8 bits of a data word.
package vin_pkg;

    typedef enum logic [1:0] {
        FMT_EMB  = 2'b00,
        FMT_SEP8 = 2'b01,
        FMT_YC16 = 2'b10,
        FMT_RSVD = 2'b11
    } vin_fmt_e;

    // True when the XY byte carries protection bits that agree with F, V, H.
    function automatic logic xy_consistent(input logic [7:0] xy);
        logic f;
        logic v;
        logic h;
        f = xy[6];
        v = xy[5];
        h = xy[4];
        return xy[7] && (xy[3] == (v ^ h)) && (xy[2] == (f ^ h))
            && (xy[1] == (f ^ v)) && (xy[0] == (f ^ v ^ h));
    endfunction

endpackage

// File: rtl/vin_trs_decode.sv
// Embedded timing code decoder.
// Watches a byte stream for the all-ones / zero / zero prefix and a checked
// XY byte, then rebuilds H/V strobes, the field bit and the active region.
// The data leaves through a delay equal to the prefix length, so the code
// bytes can be masked out of the active region before they reach the packer.
// Assumes DW >= 8; the XY flags are taken from the top byte.
module vin_trs_decode
    import vin_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] s_byte,
    output logic          s_act,
    output logic          hs_stb,
    output logic          vs_stb,
    output logic          fid
);

    localparam int ALIGN = 3;
    localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};
    localparam logic [DW-1:0] ALL_ZERO = {DW{1'b0}};

    logic [DW-1:0]    dly [ALIGN];
    logic [ALIGN-1:0] start_sr;
    logic             act_q;
    logic             v_q;
    logic [7:0]       xy;
    logic             prefix_ok;
    logic             code_ok;
    logic             eav_det;
    logic             sav_det;

    assign xy        = din[DW-1 -: 8];
    assign prefix_ok = (dly[ALIGN-1] == ALL_ONES) && (dly[1] == ALL_ZERO) && (dly[0] == ALL_ZERO);
    assign code_ok   = en && prefix_ok && xy_consistent(xy);
    assign eav_det   = code_ok && xy[4];
    assign sav_det   = code_ok && !xy[4] && !xy[5];

    // Delayed byte leaving toward the packer, gated by the active region.
    assign s_byte = dly[ALIGN-1];
    assign s_act  = act_q && !eav_det;

    // Prefix delay line and start-code alignment shift.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < ALIGN; i++) dly[i] <= ALL_ZERO;
            start_sr <= '0;
        end else begin
            dly[0] <= din;
            for (int i = 1; i < ALIGN; i++) dly[i] <= dly[i-1];
            start_sr <= {start_sr[ALIGN-2:0], sav_det};
        end
    end

    // Active region: opened once the start code has left the delay line, closed by an end code.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            act_q <= 1'b0;
        end else if (eav_det) begin
            act_q <= 1'b0;
        end else if (start_sr[ALIGN-1]) begin
            act_q <= 1'b1;
        end
    end

    // Sync strobes and field bit from accepted codes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hs_stb <= 1'b0;
            vs_stb <= 1'b0;
            v_q    <= 1'b0;
            fid    <= 1'b0;
        end else begin
            hs_stb <= eav_det;
            vs_stb <= code_ok && xy[5] && !v_q;
            if (code_ok) begin
                v_q <= xy[5];
                fid <= xy[6];
            end
        end
    end

    // R4
    hs_single_chk: assert property (@(posedge clk) disable iff (!rst_n) hs_stb |=> !hs_stb);

endmodule

// File: rtl/vin_sep_sync.sv
// Separate-sync timing for the 8-bit and 16-bit formats.
// hs_in and vs_in are blanking levels (high = blanking). Rising edges give
// one-cycle strobes, and a cycle with both low is active.
module vin_sep_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic hs_in,
    input  logic vs_in,
    input  logic fid_in,
    output logic s_act,
    output logic hs_stb,
    output logic vs_stb,
    output logic fid
);

    logic hs_q;
    logic vs_q;

    assign s_act = en && !hs_in && !vs_in;

    // Edge detection of the sync levels and field capture.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hs_q   <= 1'b0;
            vs_q   <= 1'b0;
            hs_stb <= 1'b0;
            vs_stb <= 1'b0;
            fid    <= 1'b0;
        end else begin
            hs_q   <= hs_in;
            vs_q   <= vs_in;
            hs_stb <= en && hs_in && !hs_q;
            vs_stb <= en && vs_in && !vs_q;
            if (en) fid <= fid_in;
        end
    end

    // R5
    vs_single_chk: assert property (@(posedge clk) disable iff (!rst_n) vs_stb |=> !vs_stb);

endmodule

// File: rtl/vin_pack.sv
// Output packer.
// In wide mode it registers the Y/C pair every cycle. In byte mode it splits
// the active bytes into chroma, luma, chroma, luma and presents one sample per
// luma byte, paired with the chroma byte just before it. The phase restarts
// whenever the active region drops.
module vin_pack #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wide,
    input  logic [DW-1:0] s_y,
    input  logic [DW-1:0] s_c,
    input  logic          s_act,
    output logic [DW-1:0] o_y,
    output logic [DW-1:0] o_c,
    output logic          o_act
);

    logic          luma_ph;
    logic [DW-1:0] c_hold;

    // Sample assembly for both widths.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            luma_ph <= 1'b0;
            c_hold  <= '0;
            o_y     <= '0;
            o_c     <= '0;
            o_act   <= 1'b0;
        end else if (wide) begin
            luma_ph <= 1'b0;
            o_y     <= s_y;
            o_c     <= s_c;
            o_act   <= s_act;
        end else begin
            luma_ph <= s_act ? !luma_ph : 1'b0;
            o_act   <= s_act && luma_ph;
            if (s_act && !luma_ph) c_hold <= s_y;
            if (s_act && luma_ph) begin
                o_y <= s_y;
                o_c <= c_hold;
            end
        end
    end

    // R7
    byte_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) (o_act && !wide) |=> !o_act);

endmodule

// File: rtl/vid_in_frontend.sv
// Multi-format video input front end (top).
// Selects the source path from fmt_sel/port_sel, merges the sync strobes,
// and tracks line completeness for out_valid. Any change of configuration
// clears every stage in the same cycle.
// Assumes the data clock is the only clock and all inputs are synchronous to it.
module vid_in_frontend
    import vin_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    fmt_sel,
    input  logic          port_sel,
    input  logic [DW-1:0] y_in,
    input  logic [DW-1:0] c_in,
    input  logic          hs_in,
    input  logic          vs_in,
    input  logic          fid_in,
    output logic [DW-1:0] out_y,
    output logic [DW-1:0] out_c,
    output logic          out_hs,
    output logic          out_vs,
    output logic          out_fid,
    output logic          out_act,
    output logic          out_valid
);

    vin_fmt_e      fmt;
    logic [2:0]    cfg_q;
    logic          cfg_chg;
    logic          emb_en;
    logic          sep_en;
    logic          wide;
    logic [DW-1:0] emb_byte;
    logic [DW-1:0] trs_byte;
    logic          trs_act;
    logic          trs_hs;
    logic          trs_vs;
    logic          trs_fid;
    logic          sep_act;
    logic          sep_hs;
    logic          sep_vs;
    logic          sep_fid;
    logic [DW-1:0] pk_y;
    logic          pk_act;
    logic          seen_q;

    assign fmt      = vin_fmt_e'(fmt_sel);
    assign cfg_chg  = ({fmt_sel, port_sel} != cfg_q);
    assign emb_en   = (fmt == FMT_EMB);
    assign sep_en   = (fmt == FMT_SEP8) || (fmt == FMT_YC16);
    assign wide     = (fmt == FMT_YC16);
    assign emb_byte = port_sel ? c_in : y_in;
    assign pk_y     = emb_en ? trs_byte : y_in;
    assign pk_act   = emb_en ? trs_act : sep_act;

    // Only the enabled path can raise a strobe, so the paths are simply merged.
    assign out_hs  = trs_hs | sep_hs;
    assign out_vs  = trs_vs | sep_vs;
    assign out_fid = trs_fid | sep_fid;

    vin_trs_decode #(.DW(DW)) u_trs (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cfg_chg),
        .en     (emb_en),
        .din    (emb_byte),
        .s_byte (trs_byte),
        .s_act  (trs_act),
        .hs_stb (trs_hs),
        .vs_stb (trs_vs),
        .fid    (trs_fid)
    );

    vin_sep_sync u_sep (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cfg_chg),
        .en     (sep_en),
        .hs_in  (hs_in),
        .vs_in  (vs_in),
        .fid_in (fid_in),
        .s_act  (sep_act),
        .hs_stb (sep_hs),
        .vs_stb (sep_vs),
        .fid    (sep_fid)
    );

    vin_pack #(.DW(DW)) u_pack (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_chg),
        .wide  (wide),
        .s_y   (pk_y),
        .s_c   (c_in),
        .s_act (pk_act),
        .o_y   (out_y),
        .o_c   (out_c),
        .o_act (out_act)
    );

    // Configuration history used to spot a format or port change.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= {fmt_sel, port_sel};
    end

    // Line completeness: valid after two line strobes since reset or reconfiguration.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_chg) begin
            seen_q    <= 1'b0;
            out_valid <= 1'b0;
        end else if (out_hs) begin
            seen_q <= 1'b1;
            if (seen_q) out_valid <= 1'b1;
        end
    end

    // R11
    valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) cfg_chg |=> !out_valid);

    // R11
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !cfg_chg) |=> out_valid);

    // R1
    rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel == 2'b11 && $past(fmt_sel) == 2'b11) |-> (!out_act && !out_hs && !out_vs));

    // R4
    hs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) out_hs |=> !out_hs);

endmodule

// File: tb/sim_vid_in_frontend.sv
module sim_vid_in_frontend;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] fmt_sel;
    logic       port_sel;
    logic [7:0] y_in, c_in;
    logic       hs_in, vs_in, fid_in;
    logic [7:0] out_y, out_c;
    logic       out_hs, out_vs, out_fid, out_act, out_valid;

    int checks = 0;
    int fails  = 0;
    int n      = 0;
    bit port_c = 1'b0;
    bit done   = 1'b0;

    logic [7:0] cy [0:255];
    logic [7:0] cc [0:255];
    logic       ca [0:255];
    logic       chs[0:255];
    logic       cvs[0:255];
    logic       cfd[0:255];
    logic       cvl[0:255];

    always #5 clk = ~clk;

    vid_in_frontend u0 (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .port_sel(port_sel),
        .y_in(y_in), .c_in(c_in), .hs_in(hs_in), .vs_in(vs_in), .fid_in(fid_in),
        .out_y(out_y), .out_c(out_c), .out_hs(out_hs), .out_vs(out_vs),
        .out_fid(out_fid), .out_act(out_act), .out_valid(out_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one input cycle, then capture the outputs just after the edge.
    task automatic tick(input logic [7:0] y, input logic [7:0] c, input logic h, input logic v, input logic f);
        y_in = y; c_in = c; hs_in = h; vs_in = v; fid_in = f;
        @(posedge clk);
        #1;
        if (n < 256) begin
            cy[n] = out_y; cc[n] = out_c; ca[n] = out_act; chs[n] = out_hs;
            cvs[n] = out_vs; cfd[n] = out_fid; cvl[n] = out_valid;
            n++;
        end
    endtask

    task automatic eb(input logic [7:0] b);
        if (port_c) tick(8'hA5, b, 1'b0, 1'b0, 1'b0);
        else        tick(b, 8'hA5, 1'b0, 1'b0, 1'b0);
    endtask

    function automatic logic [7:0] mk_xy(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    task automatic code(input logic [7:0] xy, output int at);
        eb(8'hFF); eb(8'h00); eb(8'h00);
        at = n;
        eb(xy);
    endtask

    function automatic int cnt(input int which);
        int s = 0;
        for (int i = 0; i < n; i++) begin
            case (which)
                0: s += int'(ca[i]);
                1: s += int'(chs[i]);
                default: s += int'(cvs[i]);
            endcase
        end
        return s;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0; n = 0;
        repeat (3) tick(8'h33, 8'h44, 1'b1, 1'b1, 1'b1);
        // R12 reset state
        chk("R12 reset out_valid", cvl[2], 0);
        chk("R12 reset out_act", ca[2], 0);
        chk("R12 reset out_hs", chs[2], 0);
        chk("R12 reset out_vs", cvs[2], 0);
        chk("R12 reset out_fid", cfd[2], 0);
        chk("R12 reset out_y", cy[2], 0);
        rst_n = 1'b1;
    endtask

    task automatic t_emb_line(input bit use_c);
        int e1, s1, e2;
        port_c = use_c; fmt_sel = 2'b00; port_sel = use_c; n = 0;
        repeat (4) eb(8'h10);
        code(mk_xy(1'b0, 1'b0, 1'b1), e1);
        repeat (4) eb(8'h80);
        code(mk_xy(1'b0, 1'b0, 1'b0), s1);
        eb(8'h40); eb(8'h50); eb(8'h60); eb(8'h51);
        eb(8'h41); eb(8'h52); eb(8'h61); eb(8'h53);
        code(mk_xy(1'b0, 1'b0, 1'b1), e2);
        repeat (6) eb(8'h10);
        if (use_c) chk("R11 port change clears valid", cvl[0], 0);
        chk("R4 hs on first end code", chs[e1], 1);
        chk("R4 hs on second end code", chs[e2], 1);
        chk("R4 hs strobe count", cnt(1), 2);
        chk("R6 sample count in line", cnt(0), 4);
        chk("R10 no sample before latency", ca[s1+4], 0);
        chk("R10 first sample at 4 edges", ca[s1+5], 1);
        chk("R2 R7 first luma", cy[s1+5], 8'h50);
        chk("R2 R7 first chroma Cb", cc[s1+5], 8'h40);
        chk("R7 second luma", cy[s1+7], 8'h51);
        chk("R7 second chroma Cr", cc[s1+7], 8'h60);
        chk("R7 third pair luma", cy[s1+9], 8'h52);
        chk("R7 third pair chroma", cc[s1+9], 8'h41);
        chk("R7 fourth pair luma", cy[s1+11], 8'h53);
        chk("R7 fourth pair chroma", cc[s1+11], 8'h61);
        chk("R11 valid low at second hs", cvl[e2], 0);
        chk("R11 valid after second hs", cvl[e2+1], 1);
    endtask

    task automatic t_bad_codes();
        int e1, s1, e2;
        port_c = 1'b0; fmt_sel = 2'b00; port_sel = 1'b0; n = 0;
        repeat (3) eb(8'h10);
        code(mk_xy(1'b0, 1'b0, 1'b1), e1);
        repeat (2) eb(8'h80);
        code(8'h81, s1);
        repeat (6) eb(8'h50);
        code(8'h9C, e2);
        repeat (6) eb(8'h10);
        chk("R3 good end code strobes", chs[e1], 1);
        chk("R3 bad end code ignored", chs[e2], 0);
        chk("R3 only one strobe", cnt(1), 1);
        chk("R3 bad start code opens nothing", cnt(0), 0);
    endtask

    task automatic t_vertical();
        int a, b, c, d;
        port_c = 1'b0; fmt_sel = 2'b00; port_sel = 1'b0; n = 0;
        repeat (2) eb(8'h10);
        code(mk_xy(1'b0, 1'b0, 1'b1), a);
        code(mk_xy(1'b0, 1'b1, 1'b0), b);
        repeat (6) eb(8'h50);
        code(mk_xy(1'b0, 1'b1, 1'b1), c);
        repeat (2) eb(8'h10);
        code(mk_xy(1'b1, 1'b0, 1'b1), d);
        repeat (3) eb(8'h10);
        chk("R5 vs on V rise", cvs[b], 1);
        chk("R5 single vs", cnt(2), 1);
        chk("R4 start code gives no hs", chs[b], 0);
        chk("R6 V=1 start opens nothing", cnt(0), 0);
        chk("R5 fid before F=1 code", cfd[d-1], 0);
        chk("R5 fid after F=1 code", cfd[d], 1);
    endtask

    task automatic t_sep8();
        fmt_sel = 2'b01; port_sel = 1'b0; n = 0;
        repeat (3) tick(8'h10, 8'h99, 1'b1, 1'b0, 1'b0);
        tick(8'h41, 8'h99, 1'b0, 1'b0, 1'b0); tick(8'h52, 8'h99, 1'b0, 1'b0, 1'b0);
        tick(8'h63, 8'h99, 1'b0, 1'b0, 1'b0); tick(8'h54, 8'h99, 1'b0, 1'b0, 1'b0);
        tick(8'h45, 8'h99, 1'b0, 1'b0, 1'b0); tick(8'h56, 8'h99, 1'b0, 1'b0, 1'b0);
        tick(8'h67, 8'h99, 1'b0, 1'b0, 1'b0); tick(8'h58, 8'h99, 1'b0, 1'b0, 1'b0);
        repeat (2) tick(8'h10, 8'h99, 1'b1, 1'b0, 1'b0);
        tick(8'h44, 8'h99, 1'b0, 1'b0, 1'b0); tick(8'h55, 8'h99, 1'b0, 1'b0, 1'b0);
        tick(8'h66, 8'h99, 1'b0, 1'b0, 1'b0); tick(8'h77, 8'h99, 1'b0, 1'b0, 1'b0);
        repeat (2) tick(8'h12, 8'h99, 1'b0, 1'b1, 1'b1);
        tick(8'h10, 8'h99, 1'b1, 1'b1, 1'b1);
        chk("R10 R7 luma one edge later", ca[4], 1);
        chk("R8 R7 luma from Y port", cy[4], 8'h52);
        chk("R8 R7 chroma from Y port", cc[4], 8'h41);
        chk("R7 Cr pairing", cc[6], 8'h63);
        chk("R7 last pair luma", cy[10], 8'h58);
        chk("R7 last pair chroma", cc[10], 8'h67);
        chk("R7 phase restarts on chroma", ca[13], 0);
        chk("R7 restarted pair luma", cy[14], 8'h55);
        chk("R7 restarted pair chroma", cc[14], 8'h44);
        chk("R8 sample count, none in vblank", cnt(0), 6);
        chk("R4 hs on rising hs_in", chs[11], 1);
        chk("R11 valid low at second hs", cvl[11], 0);
        chk("R11 valid after second hs", cvl[12], 1);
        chk("R5 vs on rising vs_in", cvs[17], 1);
        chk("R5 fid follows fid_in", cfd[17], 1);
        chk("R5 fid low before", cfd[16], 0);
        // R12 mid-run reset
        rst_n = 1'b0; n = 0;
        tick(8'h10, 8'h99, 1'b0, 1'b0, 1'b1);
        chk("R12 reset clears valid", cvl[0], 0);
        chk("R12 reset clears fid", cfd[0], 0);
        rst_n = 1'b1;
    endtask

    task automatic t_yc16();
        fmt_sel = 2'b10; port_sel = 1'b0; n = 0;
        repeat (2) tick(8'h10, 8'h99, 1'b1, 1'b0, 1'b0);
        tick(8'h20, 8'h30, 1'b0, 1'b0, 1'b0);
        tick(8'h21, 8'h31, 1'b0, 1'b0, 1'b0);
        tick(8'h22, 8'h32, 1'b0, 1'b0, 1'b0);
        tick(8'h10, 8'h99, 1'b1, 1'b0, 1'b0);
        chk("R8 blanking not active", ca[1], 0);
        chk("R9 every cycle active", cnt(0), 3);
        chk("R9 sample 0 luma", cy[2], 8'h20);
        chk("R9 sample 0 chroma", cc[2], 8'h30);
        chk("R9 R10 consecutive samples", ca[3], 1);
        chk("R9 sample 2 luma", cy[4], 8'h22);
        chk("R9 sample 2 chroma", cc[4], 8'h32);
        chk("R9 blanking ends samples", ca[5], 0);
    endtask

    task automatic t_rsvd();
        fmt_sel = 2'b11; port_sel = 1'b0; n = 0;
        tick(8'h10, 8'h00, 1'b1, 1'b0, 1'b0);
        repeat (2) tick(8'h10, 8'h00, 1'b0, 1'b0, 1'b0);
        tick(8'h10, 8'h00, 1'b1, 1'b1, 1'b0);
        tick(8'hFF, 8'h00, 1'b0, 1'b0, 1'b0); tick(8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        tick(8'h00, 8'h00, 1'b0, 1'b0, 1'b0); tick(8'h9D, 8'h00, 1'b0, 1'b0, 1'b0);
        repeat (3) tick(8'h10, 8'h00, 1'b0, 1'b0, 1'b0);
        chk("R1 reserved no samples", cnt(0), 0);
        chk("R1 reserved no hs", cnt(1), 0);
        chk("R1 reserved no vs", cnt(2), 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        rst_n = 1'b0; fmt_sel = 2'b00; port_sel = 1'b0;
        y_in = 8'h00; c_in = 8'h00; hs_in = 1'b0; vs_in = 1'b0; fid_in = 1'b0;
        t_reset();
        t_emb_line(1'b0);
        t_emb_line(1'b1);
        t_bad_codes();
        t_vertical();
        t_sep8();
        t_yc16();
        t_rsvd();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule